// File: doc/BRIEF.md
# Dual-Group Interrupt Status Controller

This block collects interrupt events into two independent groups, a normal group and an error group, and drives a single level-sensitive interrupt line to the processor. Each group holds a 32-bit status word that hardware events set and software clears, plus a 32-bit mask word that software can only change through separate "unmask" and "mask-set" write addresses. A dedicated vertical-sync pulse input lands on a fixed bit of the normal status word.

Software talks to the block through a plain 32-bit write port (strobe, word address, data) and a combinational read port (word address in, data out). The word address map is: 0 normal status, 1 normal mask, 2 normal unmask, 3 normal mask-set, 4 error status, 5 error mask, 6 error unmask, 7 error mask-set. The interrupt line is computed from the registered state, so it reflects any write or event from the clock edge that captures it.

Top module: `irqc_dual`

## Requirements
- R1: During and after a synchronous active-low reset, both status words read 0, the normal mask (address 1) reads 0x07FFFFFF, the error mask (address 5) reads 0xFFFFFFFF and `irq` is low.
- R2: A one-cycle pulse on any bit of `norm_evt` or `err_evt` sets the same bit of the normal (address 0) or error (address 4) status word at that clock edge; several bits pulsed together all become set, and set bits stay set.
- R3: A write to a status address (0 or 4) clears every status bit that is 1 in the write data and leaves the others unchanged.
- R4: A write to an unmask address (2 or 6) clears, in that group's mask, every bit that is 1 in the write data.
- R5: A write to a mask-set address (3 or 7) sets, in that group's mask, every bit that is 1 in the write data.
- R6: A direct write to a mask address (1 or 5) changes no mask bit; masks change only through addresses 2, 3, 6 and 7.
- R7: The unmask and mask-set addresses (2, 3, 6, 7) always read as 0.
- R8: `irq` is high exactly when (normal status AND NOT normal mask) or (error status AND NOT error mask) is nonzero.
- R9: A pulse on `vsync_evt` sets bit 27 of the normal status word.
- R10: When an event sets a status bit in the same cycle as a write clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| norm_evt | input | 32 | Normal-group event pulses |
| err_evt | input | 32 | Error-group event pulses |
| vsync_evt | input | 1 | Vertical-sync event pulse |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions watch every cycle that pulsed events land in status, that clearing writes remove only the written bits unless an event re-sets them, that masks move only under the unmask and mask-set strobes and in the written direction, that write-only addresses read zero and that a low `irq` means nothing unmasked is pending. The bench scenarios show what per-cycle properties cannot: the reset values of the masks, the ignored direct mask write seen through read-back, the vertical-sync bit arriving already unmasked, and whole sequences of unmask, clear and re-mask that make the interrupt line rise and fall.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared word-address map and per-group write strobe bundle for the
// dual-group interrupt controller. Addresses are word indices.
package irqc_pkg;

    localparam int unsigned RA_W = 3;

    typedef enum logic [RA_W-1:0] {
        RA_N_STAT    = 3'd0,
        RA_N_MASK    = 3'd1,
        RA_N_UNMASK  = 3'd2,
        RA_N_MASKSET = 3'd3,
        RA_E_STAT    = 3'd4,
        RA_E_MASK    = 3'd5,
        RA_E_UNMASK  = 3'd6,
        RA_E_MASKSET = 3'd7
    } reg_addr_e;

    // Write strobes that one group needs for one cycle.
    typedef struct packed {
        logic clr;      // write-one-to-clear on status
        logic unmask;   // clear mask bits
        logic maskset;  // set mask bits
    } grp_wr_t;

endpackage

// File: rtl/irqc_wdec.sv
// Module irqc_wdec
// Turns the write strobe and word address into per-group strobes.
// Assumes a single write per cycle; direct writes to a mask address
// produce no strobe at all, which makes the masks read-only there.
module irqc_wdec
    import irqc_pkg::*;
(
    input  logic            wr_en,
    input  logic [RA_W-1:0] wr_addr,
    output grp_wr_t         n_wr,
    output grp_wr_t         e_wr
);

    // Address decode into strobes for the normal and error groups.
    always_comb begin
        n_wr = '0;
        e_wr = '0;
        if (wr_en) begin
            case (wr_addr)
                RA_N_STAT:    n_wr.clr     = 1'b1;
                RA_N_UNMASK:  n_wr.unmask  = 1'b1;
                RA_N_MASKSET: n_wr.maskset = 1'b1;
                RA_E_STAT:    e_wr.clr     = 1'b1;
                RA_E_UNMASK:  e_wr.unmask  = 1'b1;
                RA_E_MASKSET: e_wr.maskset = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irqc_group.sv
// Module irqc_group
// One interrupt group: a status word set by event pulses and cleared by
// write-one-to-clear, and a mask word changed only by unmask/mask-set
// strobes. Events win over a clear of the same bit in the same cycle.
// Assumes unmask and mask-set never arrive together (one write per cycle).
module irqc_group
    import irqc_pkg::*;
#(
    parameter int unsigned W        = 32,
    parameter logic [W-1:0] RST_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  grp_wr_t      wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] mask_o,
    output logic         pend_o
);

    logic [W-1:0] clr_bits;
    logic [W-1:0] status_nxt;
    logic [W-1:0] mask_nxt;

    // Bits that software asks to clear this cycle.
    assign clr_bits = wr_i.clr ? wdata_i : '0;

    // Next status: keep, drop cleared bits, then OR in new events.
    assign status_nxt = (status_o & ~clr_bits) | set_i;

    // Next mask: unmask clears written bits, mask-set sets them.
    always_comb begin
        mask_nxt = mask_o;
        if (wr_i.unmask) begin
            mask_nxt = mask_o & ~wdata_i;
        end else if (wr_i.maskset) begin
            mask_nxt = mask_o | wdata_i;
        end
    end

    // Status register with synchronous reset to all-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= status_nxt;
        end
    end

    // Mask register with synchronous reset to the group's reset mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= RST_MASK;
        end else begin
            mask_o <= mask_nxt;
        end
    end

    // Any unmasked pending bit in this group.
    assign pend_o = |(status_o & ~mask_o);

endmodule

// File: rtl/irqc_rdmux.sv
// Module irqc_rdmux
// Combinational read-back of both groups. Write-only addresses
// (unmask and mask-set) return zero.
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [RA_W-1:0] rd_addr,
    input  logic [W-1:0]    n_status,
    input  logic [W-1:0]    n_mask,
    input  logic [W-1:0]    e_status,
    input  logic [W-1:0]    e_mask,
    output logic [W-1:0]    rd_data
);

    // Select the addressed readable word, zero otherwise.
    always_comb begin
        case (rd_addr)
            RA_N_STAT: rd_data = n_status;
            RA_N_MASK: rd_data = n_mask;
            RA_E_STAT: rd_data = e_status;
            RA_E_MASK: rd_data = e_mask;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irqc_dual.sv
// Module irqc_dual
// Top of the dual-group interrupt controller. Two irqc_group instances
// (normal, error) share one write port and one read port; the vertical
// sync pulse is merged into the normal group's set vector at VSYNC_BIT.
// The interrupt line is the OR of both groups' unmasked pending flags.
// Assumes event inputs are one-cycle pulses synchronous to clk.
module irqc_dual
    import irqc_pkg::*;
#(
    parameter int unsigned W          = 32,
    parameter int unsigned VSYNC_BIT  = 27,
    parameter logic [W-1:0] N_RST_MASK = 32'h07FF_FFFF,
    parameter logic [W-1:0] E_RST_MASK = 32'hFFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RA_W-1:0] wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic [RA_W-1:0] rd_addr,
    output logic [W-1:0]    rd_data,
    input  logic [W-1:0]    norm_evt,
    input  logic [W-1:0]    err_evt,
    input  logic            vsync_evt,
    output logic            irq
);

    grp_wr_t      n_wr;
    grp_wr_t      e_wr;
    logic [W-1:0] n_set;
    logic [W-1:0] n_status;
    logic [W-1:0] n_mask;
    logic [W-1:0] e_status;
    logic [W-1:0] e_mask;
    logic         n_pend;
    logic         e_pend;

    // Merge the vertical-sync pulse into the normal set vector.
    generate
        if (VSYNC_BIT < W) begin : g_vs
            always_comb begin
                n_set            = norm_evt;
                n_set[VSYNC_BIT] = norm_evt[VSYNC_BIT] | vsync_evt;
            end
        end else begin : g_novs
            assign n_set = norm_evt;
        end
    endgenerate

    irqc_wdec u_wdec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .n_wr    (n_wr),
        .e_wr    (e_wr)
    );

    irqc_group #(.W(W), .RST_MASK(N_RST_MASK)) u_norm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (n_set),
        .wr_i     (n_wr),
        .wdata_i  (wr_data),
        .status_o (n_status),
        .mask_o   (n_mask),
        .pend_o   (n_pend)
    );

    irqc_group #(.W(W), .RST_MASK(E_RST_MASK)) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (err_evt),
        .wr_i     (e_wr),
        .wdata_i  (wr_data),
        .status_o (e_status),
        .mask_o   (e_mask),
        .pend_o   (e_pend)
    );

    irqc_rdmux #(.W(W)) u_rd (
        .rd_addr  (rd_addr),
        .n_status (n_status),
        .n_mask   (n_mask),
        .e_status (e_status),
        .e_mask   (e_mask),
        .rd_data  (rd_data)
    );

    // Single level output from both groups.
    assign irq = n_pend | e_pend;

endmodule

// File: rtl/irqc_dual_chk.sv
// Module irqc_dual_chk
// Property checker for irqc_dual, attached by bind below. Observes ports
// and the registered status/mask words of both groups.
module irqc_dual_chk
    import irqc_pkg::*;
#(
    parameter int unsigned W         = 32,
    parameter int unsigned VSYNC_BIT = 27
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [RA_W-1:0] wr_addr,
    input logic [W-1:0]    wr_data,
    input logic [RA_W-1:0] rd_addr,
    input logic [W-1:0]    rd_data,
    input logic [W-1:0]    norm_evt,
    input logic [W-1:0]    err_evt,
    input logic            vsync_evt,
    input logic            irq,
    input logic [W-1:0]    n_status,
    input logic [W-1:0]    n_mask,
    input logic [W-1:0]    e_status,
    input logic [W-1:0]    e_mask
);

    logic [W-1:0] vs_vec;
    logic         n_mwr;
    logic         e_mwr;

    assign vs_vec = vsync_evt ? (W'(1) << VSYNC_BIT) : '0;
    assign n_mwr  = wr_en && (wr_addr == RA_N_UNMASK || wr_addr == RA_N_MASKSET);
    assign e_mwr  = wr_en && (wr_addr == RA_E_UNMASK || wr_addr == RA_E_MASKSET);

    // R2 R10
    norm_evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (norm_evt != '0) |=> ((n_status & $past(norm_evt)) == $past(norm_evt)));
    // R2 R10
    err_evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt != '0) |=> ((e_status & $past(err_evt)) == $past(err_evt)));
    // R3
    norm_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_N_STAT)
        |=> ((n_status & $past(wr_data) & ~$past(norm_evt | vs_vec)) == '0));
    // R3
    err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_E_STAT)
        |=> ((e_status & $past(wr_data) & ~$past(err_evt)) == '0));
    // R4
    norm_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_N_UNMASK) |=> ((n_mask & $past(wr_data)) == '0));
    // R5
    err_maskset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_E_MASKSET)
        |=> ((e_mask & $past(wr_data)) == $past(wr_data)));
    // R6
    norm_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !n_mwr |=> $stable(n_mask));
    // R6
    err_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !e_mwr |=> $stable(e_mask));
    // R7
    wo_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == RA_N_UNMASK || rd_addr == RA_N_MASKSET ||
         rd_addr == RA_E_UNMASK || rd_addr == RA_E_MASKSET) |-> (rd_data == '0));
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> ((n_status & ~n_mask) == '0 && (e_status & ~e_mask) == '0));
    // R9
    vsync_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_evt |=> n_status[VSYNC_BIT]);

endmodule

bind irqc_dual irqc_dual_chk #(.W(W), .VSYNC_BIT(VSYNC_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .norm_evt  (norm_evt),
    .err_evt   (err_evt),
    .vsync_evt (vsync_evt),
    .irq       (irq),
    .n_status  (n_status),
    .n_mask    (n_mask),
    .e_status  (e_status),
    .e_mask    (e_mask)
);

// File: tb/irqc_dual_test.sv
`timescale 1ns/1ps
// Scoreboard bench for irqc_dual: driver tasks update a requirement-level
// model and push expected read-back items; a monitor pops and compares.
module irqc_dual_test;

    localparam int unsigned W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [W-1:0]  rd_data;
    logic [W-1:0]  norm_evt = '0;
    logic [W-1:0]  err_evt = '0;
    logic          vsync_evt = 1'b0;
    logic          irq;

    irqc_dual uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .norm_evt(norm_evt), .err_evt(err_evt), .vsync_evt(vsync_evt),
        .irq(irq)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [2:0]   addr;
        logic [W-1:0] dat;
        logic         irq_x;
        string        req;
    } item_t;

    item_t  sb_q[$];
    event   sample_ev;
    int     n_vec  = 0;
    int     n_miss = 0;
    bit     done   = 0;

    // Requirement model
    logic [W-1:0] m_ns, m_nm, m_es, m_em;

    function automatic logic [W-1:0] mdl_read(input logic [2:0] a);
        case (a)
            3'd0: return m_ns;
            3'd1: return m_nm;
            3'd4: return m_es;
            3'd5: return m_em;
            default: return '0;
        endcase
    endfunction

    // One cycle of stimulus, applied at a falling edge.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [W-1:0] d,
                       input logic [W-1:0] ne, input logic [W-1:0] ee, input logic vs);
        logic [W-1:0] nset;
        wr_en = we; wr_addr = a; wr_data = d;
        norm_evt = ne; err_evt = ee; vsync_evt = vs;
        nset = ne | (vs ? (W'(1) << 27) : '0);
        m_ns = (m_ns & ~((we && a == 3'd0) ? d : '0)) | nset;
        m_es = (m_es & ~((we && a == 3'd4) ? d : '0)) | ee;
        if (we && a == 3'd2) m_nm = m_nm & ~d;
        if (we && a == 3'd3) m_nm = m_nm | d;
        if (we && a == 3'd6) m_em = m_em & ~d;
        if (we && a == 3'd7) m_em = m_em | d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; norm_evt = '0; err_evt = '0; vsync_evt = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        cyc(1'b1, a, d, '0, '0, 1'b0);
    endtask

    // Push an expected read-back and trigger the monitor.
    task automatic chk(input logic [2:0] a, input string req);
        item_t it;
        rd_addr  = a;
        it.addr  = a;
        it.dat   = mdl_read(a);
        it.irq_x = |(m_ns & ~m_nm) | |(m_es & ~m_em);
        it.req   = req;
        sb_q.push_back(it);
        -> sample_ev;
        @(negedge clk);
    endtask

    // Monitor: compare design outputs against queued expectations.
    initial begin
        forever begin
            item_t it;
            @(sample_ev);
            #1;
            it = sb_q.pop_front();
            n_vec++;
            if (rd_data !== it.dat || irq !== it.irq_x) begin
                n_miss++;
                $display("FAIL %s addr=%0d rd_data=%h expected=%h irq=%b expected=%b",
                         it.req, it.addr, rd_data, it.dat, irq, it.irq_x);
            end
        end
    end

    // Watchdog
    initial begin
        #100000;
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        m_ns = '0; m_nm = 32'h07FF_FFFF; m_es = '0; m_em = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset values read during reset, then after release
        chk(3'd1, "R1");
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) chk(3'(a), (a % 4 >= 2) ? "R7" : "R1");

        // R2 several normal bits in one cycle, still masked
        cyc(1'b0, 3'd0, '0, 32'h0000_0005, '0, 1'b0);
        chk(3'd0, "R2");
        // R4 R8 unmask bit 0 raises irq
        wr(3'd2, 32'h0000_0001);
        chk(3'd1, "R4 R8");
        // R6 direct mask write ignored
        wr(3'd1, 32'h0000_0000);
        chk(3'd1, "R6");
        // R3 W1C clear bit 0 drops irq, bit 2 remains
        wr(3'd0, 32'h0000_0001);
        chk(3'd0, "R3 R8");
        // R4 then R5: unmask bit 2, mask it again
        wr(3'd2, 32'h0000_0004);
        chk(3'd1, "R4 R8");
        wr(3'd3, 32'h0000_0004);
        chk(3'd1, "R5 R8");
        // R9 vsync lands on bit 27, unmasked from reset
        cyc(1'b0, 3'd0, '0, '0, '0, 1'b1);
        chk(3'd0, "R9 R8");
        wr(3'd0, 32'h0800_0000);
        chk(3'd0, "R3");
        // R2 error group event, masked
        cyc(1'b0, 3'd0, '0, '0, 32'h0000_0080, 1'b0);
        chk(3'd4, "R2");
        // R4 error unmask raises irq
        wr(3'd6, 32'h0000_0080);
        chk(3'd5, "R4 R8");
        // R3 error W1C
        wr(3'd4, 32'h0000_0080);
        chk(3'd4, "R3 R8");
        // R10 set and clear of bit 7 in the same cycle: bit stays set
        cyc(1'b1, 3'd4, 32'h0000_0080, '0, 32'h0000_0080, 1'b0);
        chk(3'd4, "R10");
        // R10 normal group: vsync and clear of bit 27 together
        cyc(1'b1, 3'd0, 32'h0800_0004, 32'h0000_0030, '0, 1'b1);
        chk(3'd0, "R10 R2");
        // R6 direct error mask write ignored
        wr(3'd5, 32'h0000_0000);
        chk(3'd5, "R6");
        // R5 error mask-set drops irq contribution
        wr(3'd7, 32'hFFFF_FFFF);
        chk(3'd5, "R5");
        // R7 write-only addresses still read zero after writes
        chk(3'd3, "R7");
        chk(3'd6, "R7");

        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule